// File: doc/BRIEF.md
# Descriptor chain walker

This block is the front end of a memory-to-flash transfer path. Software writes the address of a first command descriptor, and the walker takes over from there. It reads each descriptor over a 32-bit request/response memory port and turns it into one command for the transfer engine. When the engine reports that the command is finished, the walker follows the link to the next descriptor. This continues until it reaches a descriptor that marks itself as the last one. At that point it raises a chain-complete flag.

A descriptor occupies three consecutive 32-bit words. In order they are the data buffer address, the link to the next descriptor, and a control word. In the control word, bit 0 is the direction, bits 3:1 are the lane mode, bit 8 is the continuation flag and bits 31:16 are the byte count. Bits 7:4 and 15:9 carry no meaning. The walk ends when a descriptor with the continuation flag clear has completed. The link word of that descriptor is never followed. Buffers are 32-byte aligned, so the walker clears the low five address bits before it presents a buffer address. A response error abandons the walk and raises a separate error flag. The current descriptor address and the current buffer address are always visible on status outputs.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset the walker is idle. No memory request and no command is pending, both flags are low, and both status addresses read zero.
- R2: A start pulse accepted while idle fetches the descriptor's three words at start_addr, +4 and +8, strictly in that order. Only one request is outstanding at a time, and a request holds its address until accepted.
- R3: The command carries direction = control bit 0, lane mode = bits 3:1, continuation = bit 8, length = bits 31:16, and the buffer address with bits 4:0 cleared. Reserved bits 7:4 and 15:9 have no effect. cmd_valid and all command fields hold steady until cmd_ready.
- R4: When a command with the continuation bit set completes (xfer_done), the next fetch begins at the link word of that descriptor, and cur_desc_addr shows that link.
- R5: When a command with the continuation bit clear completes, irq_chain_done goes high and the walker returns to idle with no further memory request.
- R6: A descriptor whose length is zero issues no command. The walker moves straight on to the link or to chain completion, as its continuation bit says.
- R7: A start pulse is ignored while a walk is in progress and while irq_chain_done is high. sts_clear clears both flags, after which a start is accepted again.
- R8: A memory response with mem_rsp_err set raises irq_bus_err, abandons the walk with no command issued, and does not raise irq_chain_done.
- R9: cur_mem_addr shows the aligned buffer address of the descriptor most recently fetched.
- R10: An xfer_done pulse while no command is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_valid | input | 1 | Write strobe for the first-descriptor address |
| start_addr | input | AW | Address of the first descriptor |
| sts_clear | input | 1 | Clears both status flags |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Response carries a bus error |
| cmd_valid | output | 1 | Command offered to the transfer engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_dir | output | 1 | Direction bit |
| cmd_lanes | output | 3 | Lane mode |
| cmd_frag | output | 1 | Continuation bit |
| cmd_len | output | 16 | Byte count |
| cmd_buf_addr | output | AW | Aligned buffer address |
| xfer_done | input | 1 | Engine finished the current command |
| irq_chain_done | output | 1 | Chain-complete flag |
| irq_bus_err | output | 1 | Bus-error flag |
| cur_desc_addr | output | AW | Address of the descriptor being handled |
| cur_mem_addr | output | AW | Buffer address of the current descriptor |

## Verification
The bench uses five patterns:
- A single terminal descriptor with an unaligned buffer address. This separates correct field extraction and masking from a straight copy of the word.
- A three-link chain with a zero-length middle link and reserved bits set. This shows whether links are followed, empty links are skipped and reserved bits are ignored.
- A lone zero-length terminal descriptor. This shows whether completion happens without any command.
- A chain that fails on its second word. This shows whether an error stops the walk short of a command and without a completion flag.
- Stray start and done pulses, sent while busy, while complete and while idle. These show whether the walker ignores them.

The engine's acceptance delay changes between runs, so the command-hold rule is exercised with and without back-pressure.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

   localparam int CTRL_DIR_BIT  = 0;
   localparam int CTRL_LANE_LSB = 1;
   localparam int CTRL_FRAG_BIT = 8;
   localparam int CTRL_LEN_LSB  = 16;
   localparam int CTRL_LEN_W    = 16;
   localparam int DESC_WORDS    = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_ISSUE = 2'd2,
      ST_RUN   = 2'd3
   } walk_st_t;

   typedef struct packed {
      logic                  dir;
      logic [2:0]            lanes;
      logic                  frag;
      logic [CTRL_LEN_W-1:0] len;
   } ctrl_t;

endpackage

// File: rtl/dcw_ctrl_decode.sv
module dcw_ctrl_decode
   import dcw_pkg::*;
(
   input  logic [31:0] word,
   output ctrl_t       fields
);
   logic unused_rsvd;

   assign fields.dir   = word[CTRL_DIR_BIT];
   assign fields.lanes = word[CTRL_LANE_LSB +: 3];
   assign fields.frag  = word[CTRL_FRAG_BIT];
   assign fields.len   = word[CTRL_LEN_LSB +: CTRL_LEN_W];
   assign unused_rsvd  = ^{word[7:4], word[15:9]};
endmodule

// File: rtl/dcw_align.sv
module dcw_align #(
   parameter int AW         = 32,
   parameter int ALIGN_LOG2 = 5
) (
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out
);
   initial begin
      if (ALIGN_LOG2 < 0 || ALIGN_LOG2 >= AW)
         $error("dcw_align: ALIGN_LOG2 out of range");
   end

   generate
      if (ALIGN_LOG2 == 0) begin : g_pass
         assign addr_out = addr_in;
      end else begin : g_mask
         logic unused_low;
         assign addr_out   = {addr_in[AW-1:ALIGN_LOG2], {ALIGN_LOG2{1'b0}}};
         assign unused_low = ^addr_in[ALIGN_LOG2-1:0];
      end
   endgenerate
endmodule

// File: rtl/dcw_word_fetch.sv
module dcw_word_fetch #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          want,
   input  logic [AW-1:0] addr_in,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid
);
   logic outstanding_q;

   assign mem_req_valid = want && !outstanding_q;
   assign mem_req_addr  = addr_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outstanding_q <= 1'b0;
      end else if (mem_rsp_valid) begin
         outstanding_q <= 1'b0;
      end else if (mem_req_valid && mem_req_ready) begin
         outstanding_q <= 1'b1;
      end
   end

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready && !mem_rsp_valid |=> mem_req_valid && $stable(mem_req_addr));
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
   import dcw_pkg::*;
#(
   parameter int AW         = 32,
   parameter int ALIGN_LOG2 = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_valid,
   input  logic [AW-1:0]         start_addr,
   input  logic                  sts_clear,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [AW-1:0]         mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [31:0]           mem_rsp_data,
   input  logic                  mem_rsp_err,
   output logic                  cmd_valid,
   input  logic                  cmd_ready,
   output logic                  cmd_dir,
   output logic [2:0]            cmd_lanes,
   output logic                  cmd_frag,
   output logic [CTRL_LEN_W-1:0] cmd_len,
   output logic [AW-1:0]         cmd_buf_addr,
   input  logic                  xfer_done,
   output logic                  irq_chain_done,
   output logic                  irq_bus_err,
   output logic [AW-1:0]         cur_desc_addr,
   output logic [AW-1:0]         cur_mem_addr
);
   localparam int OFS_SH = $clog2(WORD_BYTES);
   localparam int IDX_W  = $clog2(DESC_WORDS);

   initial begin
      if (AW < 8 || AW > 32) $error("desc_chain_walker: AW must be 8..32");
      if (WORD_BYTES != 4)   $error("desc_chain_walker: words are 32-bit");
   end

   walk_st_t         st_q;
   logic [IDX_W-1:0] widx_q;
   logic [AW-1:0]    desc_q, next_q, buf_q, buf_aligned, fetch_addr;
   ctrl_t            ctrl_q, ctrl_dec;
   logic             done_q, err_q;

   dcw_ctrl_decode u_dec (.word(mem_rsp_data), .fields(ctrl_dec));

   dcw_align #(.AW(AW), .ALIGN_LOG2(ALIGN_LOG2)) u_align (
      .addr_in (mem_rsp_data[AW-1:0]),
      .addr_out(buf_aligned)
   );

   assign fetch_addr = desc_q + (AW'(widx_q) << OFS_SH);

   dcw_word_fetch #(.AW(AW)) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .want         (st_q == ST_FETCH),
      .addr_in      (fetch_addr),
      .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready),
      .mem_req_addr (mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         widx_q <= '0;
         desc_q <= '0;
         next_q <= '0;
         buf_q  <= '0;
         ctrl_q <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (sts_clear) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end
         unique case (st_q)
            ST_IDLE: begin
               if (start_valid && !done_q) begin
                  desc_q <= start_addr;
                  widx_q <= '0;
                  st_q   <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_rsp_valid) begin
                  if (mem_rsp_err) begin
                     err_q  <= 1'b1;
                     widx_q <= '0;
                     st_q   <= ST_IDLE;
                  end else if (widx_q == IDX_W'(0)) begin
                     buf_q  <= buf_aligned;
                     widx_q <= IDX_W'(1);
                  end else if (widx_q == IDX_W'(1)) begin
                     next_q <= mem_rsp_data[AW-1:0];
                     widx_q <= IDX_W'(2);
                  end else begin
                     ctrl_q <= ctrl_dec;
                     widx_q <= '0;
                     if (ctrl_dec.len != '0) begin
                        st_q <= ST_ISSUE;
                     end else if (ctrl_dec.frag) begin
                        desc_q <= next_q;
                     end else begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                     end
                  end
               end
            end
            ST_ISSUE: begin
               if (cmd_ready) st_q <= ST_RUN;
            end
            ST_RUN: begin
               if (xfer_done) begin
                  if (ctrl_q.frag) begin
                     desc_q <= next_q;
                     st_q   <= ST_FETCH;
                  end else begin
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid      = (st_q == ST_ISSUE);
   assign cmd_dir        = ctrl_q.dir;
   assign cmd_lanes      = ctrl_q.lanes;
   assign cmd_frag       = ctrl_q.frag;
   assign cmd_len        = ctrl_q.len;
   assign cmd_buf_addr   = buf_q;
   assign irq_chain_done = done_q;
   assign irq_bus_err    = err_q;
   assign cur_desc_addr  = desc_q;
   assign cur_mem_addr   = buf_q;

   // R3
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid &&
         $stable({cmd_dir, cmd_lanes, cmd_frag, cmd_len, cmd_buf_addr}));

   // R6
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_len != '0);

   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_chain_done) |-> st_q == ST_IDLE && !cmd_valid);

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_chain_done |-> !mem_req_valid && !cmd_valid);

   // R8
   err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_bus_err) |-> !cmd_valid && !mem_req_valid);
endmodule

// File: tb/sim_desc_chain_walker.sv
module sim_desc_chain_walker;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_valid = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic sts_clear = 1'b0;
   logic mem_req_valid;
   logic mem_req_ready = 1'b1;
   logic [AW-1:0] mem_req_addr;
   logic mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic mem_rsp_err = 1'b0;
   logic cmd_valid, cmd_ready = 1'b0;
   logic cmd_dir, cmd_frag;
   logic [2:0] cmd_lanes;
   logic [15:0] cmd_len;
   logic [AW-1:0] cmd_buf_addr;
   logic eng_done = 1'b0, stray_done = 1'b0;
   logic irq_chain_done, irq_bus_err;
   logic [AW-1:0] cur_desc_addr, cur_mem_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   desc_chain_walker u0 (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
      .sts_clear(sts_clear), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .mem_rsp_err(mem_rsp_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_dir(cmd_dir), .cmd_lanes(cmd_lanes), .cmd_frag(cmd_frag), .cmd_len(cmd_len),
      .cmd_buf_addr(cmd_buf_addr), .xfer_done(eng_done | stray_done),
      .irq_chain_done(irq_chain_done), .irq_bus_err(irq_bus_err),
      .cur_desc_addr(cur_desc_addr), .cur_mem_addr(cur_mem_addr)
   );

   int checks = 0, fails = 0;
   bit finished = 1'b0;
   logic [31:0] mem [0:255];
   logic [31:0] exp_addr_q [$];
   logic [52:0] exp_cmd_q [$];
   logic [31:0] err_addr = 32'hFFFF_FFFF;
   logic [31:0] pend_addr = '0;
   bit pend = 1'b0;
   int hold_lim = 0, hold_cnt = 0, run_cnt = 0, cmd_seen = 0, req_seen = 0;

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // Driver: write one descriptor and push the expected bus traffic
   task automatic put_desc(input logic [31:0] at, input logic [31:0] bufa, input logic [31:0] nxt,
                           input bit dir, input logic [2:0] lanes, input bit frag,
                           input logic [15:0] len, input bit rsvd);
      mem[at[9:2]]     = bufa;
      mem[at[9:2] + 1] = nxt;
      mem[at[9:2] + 2] = {len, 7'(rsvd ? 7'h7F : 7'h0), frag, 4'(rsvd ? 4'hF : 4'h0), lanes, dir};
      exp_addr_q.push_back(at);
      exp_addr_q.push_back(at + 4);
      exp_addr_q.push_back(at + 8);
      if (len != 0)
         exp_cmd_q.push_back({dir, lanes, frag, len, bufa & 32'hFFFF_FFE0});
   endtask

   task automatic pulse_start(input logic [31:0] a);
      @(negedge clk); start_valid = 1'b1; start_addr = a;
      @(negedge clk); start_valid = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk); sts_clear = 1'b1;
      @(negedge clk); sts_clear = 1'b0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (irq_chain_done || irq_bus_err) break;
      end
      repeat (4) @(negedge clk);
   endtask

   // Memory model and engine model, with scoreboard monitors
   always @(negedge clk) begin
      if (mem_rsp_valid) begin
         mem_rsp_valid = 1'b0;
         mem_rsp_err   = 1'b0;
      end else if (pend) begin
         pend = 1'b0;
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = mem[pend_addr[9:2]];
         mem_rsp_err   = (pend_addr == err_addr);
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
         req_seen++;
         if (exp_addr_q.size() == 0) begin
            chk(1'b0, "R2 unexpected request", 64'(mem_req_addr), 64'hFFFF);
         end else begin
            logic [31:0] ea;
            ea = exp_addr_q.pop_front();
            chk(mem_req_addr == ea, "R2 fetch address", 64'(mem_req_addr), 64'(ea));
         end
         pend = 1'b1;
         pend_addr = mem_req_addr;
      end

      eng_done = 1'b0;
      if (cmd_ready) begin
         cmd_ready = 1'b0;
         run_cnt = 3;
      end else if (run_cnt > 0) begin
         run_cnt--;
         if (run_cnt == 0) eng_done = 1'b1;
      end else if (rst_n && cmd_valid) begin
         if (hold_cnt >= hold_lim) begin
            logic [52:0] got;
            got = {cmd_dir, cmd_lanes, cmd_frag, cmd_len, cmd_buf_addr};
            cmd_seen++;
            if (exp_cmd_q.size() == 0) begin
               chk(1'b0, "R6 unexpected command", 64'(got), 64'h0);
            end else begin
               logic [52:0] ec;
               ec = exp_cmd_q.pop_front();
               chk(got == ec, "R3 command fields", 64'(got), 64'(ec));
            end
            cmd_ready = 1'b1;
            hold_cnt = 0;
         end else begin
            hold_cnt++;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int rs;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!mem_req_valid && !cmd_valid, "R1 idle outputs", 64'({mem_req_valid, cmd_valid}), 64'h0);
      chk(!irq_chain_done && !irq_bus_err, "R1 flags", 64'({irq_chain_done, irq_bus_err}), 64'h0);
      chk(cur_desc_addr == 0 && cur_mem_addr == 0, "R1 status addrs",
          64'({cur_desc_addr, cur_mem_addr}), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Single terminal descriptor, unaligned buffer (R2, R3, R5, R9)
      hold_lim = 2;
      put_desc(32'h40, 32'h1000_0025, 32'h0000_0300, 1'b1, 3'd3, 1'b0, 16'd16, 1'b0);
      pulse_start(32'h40);
      wait_end();
      chk(irq_chain_done == 1'b1, "R5 chain done", 64'(irq_chain_done), 64'h1);
      chk(!irq_bus_err, "R8 no error flag", 64'(irq_bus_err), 64'h0);
      chk(cur_desc_addr == 32'h40, "R9 cur desc", 64'(cur_desc_addr), 64'h40);
      chk(cur_mem_addr == 32'h1000_0020, "R9 cur mem aligned", 64'(cur_mem_addr), 64'h1000_0020);
      chk(exp_addr_q.size() == 0 && exp_cmd_q.size() == 0, "R5 all items seen",
          64'(exp_addr_q.size() + exp_cmd_q.size()), 64'h0);

      // Start while done flag set is ignored (R7)
      rs = req_seen;
      pulse_start(32'h80);
      repeat (10) @(negedge clk);
      chk(req_seen == rs, "R7 start ignored while done", 64'(req_seen - rs), 64'h0);
      clear_flags();
      chk(!irq_chain_done && !irq_bus_err, "R7 clear flags", 64'({irq_chain_done, irq_bus_err}), 64'h0);

      // Stray done while idle has no effect (R10)
      rs = req_seen;
      @(negedge clk); stray_done = 1'b1;
      @(negedge clk); stray_done = 1'b0;
      repeat (5) @(negedge clk);
      chk(req_seen == rs && !irq_chain_done && !cmd_valid, "R10 stray done ignored",
          64'({req_seen - rs, 31'(irq_chain_done)}), 64'h0);

      // Three-link chain, zero-length middle, reserved bits set (R3, R4, R6, R7)
      hold_lim = 0;
      put_desc(32'h100, 32'h2000_0040, 32'h200, 1'b1, 3'd1, 1'b1, 16'd64, 1'b1);
      put_desc(32'h200, 32'h2000_1000, 32'h180, 1'b0, 3'd2, 1'b1, 16'd0, 1'b1);
      put_desc(32'h180, 32'h3000_00FF, 32'h0000_0000, 1'b0, 3'd2, 1'b0, 16'd8, 1'b1);
      pulse_start(32'h100);
      pulse_start(32'h3C0);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (cur_desc_addr != 32'h100) break;
      end
      chk(cur_desc_addr == 32'h200, "R4 follows link", 64'(cur_desc_addr), 64'h200);
      wait_end();
      chk(irq_chain_done == 1'b1, "R5 chain done after links", 64'(irq_chain_done), 64'h1);
      chk(cur_desc_addr == 32'h180, "R4 last link", 64'(cur_desc_addr), 64'h180);
      chk(cur_mem_addr == 32'h3000_00E0, "R9 last buffer", 64'(cur_mem_addr), 64'h3000_00E0);
      chk(exp_addr_q.size() == 0 && exp_cmd_q.size() == 0, "R6 chain items seen",
          64'(exp_addr_q.size() + exp_cmd_q.size()), 64'h0);
      clear_flags();

      // Lone zero-length terminal descriptor (R6)
      rs = cmd_seen;
      put_desc(32'h280, 32'h4000_0000, 32'h0, 1'b1, 3'd1, 1'b0, 16'd0, 1'b0);
      pulse_start(32'h280);
      wait_end();
      chk(irq_chain_done && cmd_seen == rs, "R6 empty chain completes",
          64'({cmd_seen - rs, 31'(irq_chain_done)}), 64'h1);
      clear_flags();

      // Error on second word (R8)
      rs = cmd_seen;
      err_addr = 32'h304;
      mem[8'hC0] = 32'h5000_0000;
      exp_addr_q.push_back(32'h300);
      exp_addr_q.push_back(32'h304);
      pulse_start(32'h300);
      wait_end();
      chk(irq_bus_err == 1'b1, "R8 error flag", 64'(irq_bus_err), 64'h1);
      chk(!irq_chain_done, "R8 no chain done", 64'(irq_chain_done), 64'h0);
      chk(cmd_seen == rs && exp_addr_q.size() == 0, "R8 walk abandoned",
          64'(cmd_seen - rs), 64'h0);
      err_addr = 32'hFFFF_FFFF;
      clear_flags();

      // Recovery after error with back-pressure (R2, R3)
      hold_lim = 3;
      put_desc(32'h3A0, 32'h6000_0031, 32'h0, 1'b1, 3'd3, 1'b0, 16'd4, 1'b0);
      pulse_start(32'h3A0);
      wait_end();
      chk(irq_chain_done && !irq_bus_err, "R7 restart after clear",
          64'({irq_chain_done, irq_bus_err}), 64'h2);
      chk(exp_cmd_q.size() == 0, "R3 command delivered", 64'(exp_cmd_q.size()), 64'h0);

      finish_run();
   end
endmodule